// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Engine

This block moves a rectangle of 8-bit pixels from one place in a frame buffer to another place in the same buffer. Each destination pixel is formed by a raster operation that combines the source pixel, the old destination pixel and a plane mask. The engine drives a single-port pixel memory with a fixed line pitch. For each pixel it reads the source, reads the destination and writes the result.

The engine picks its scan directions from where the destination lies relative to the source. This keeps the source intact until it has been read, so scrolling in place works for any overlap.

A copy starts on one of two triggers. The first takes the destination from its own input. The second takes the destination from the current start-position input, so a change of size alone can launch a copy. A non-zero control-plane word blocks both triggers. The engine raises busy while it works and pulses done when it finishes.

Top module: `rect_copy_engine`

## Requirements
- R1: Every coordinate and size is a 32-bit word with x in bits 31:16 and y in bits 15:0. A pixel sits at the linear address x + y * PITCH.
- R2: When the destination y is larger than the source y, rows are visited from the last row back to the first. Otherwise rows are visited from the first row to the last.
- R3: When the destination x is larger than the source x, the columns of each row are visited right to left. Otherwise they are visited left to right.
- R4: The raster-op code and the plane mask m are captured at the trigger. The new destination value is computed from source s and old destination d as follows:
  - code 0: d & ~m
  - code 3: (d & ~m) | (s & m)
  - code 6: d ^ (s & m)
  - code 10: d ^ m
  - code 15: d | m
  - any other code: d unchanged, but still written back.
- R5: A pixel whose source or destination address is not below PITCH * ROWS is skipped. It takes one cycle, makes no memory access, and the copy then moves on to the next pixel.
- R6: A pulse on go_dst_i starts a copy to dst_xy_i. A pulse on go_size_i starts a copy to start_xy_i, and dst_xy_i is then ignored. If both pulse in the same cycle, go_dst_i wins.
- R7: A trigger that arrives while ctrl_plane_i is non-zero has no effect: no busy, no done and no memory access.
- R8: A trigger whose width or height is zero pulses done in the next cycle without going busy and without any memory access.
- R9: done is high for exactly one cycle, the cycle after the final pixel's write or skip, and busy is low in that cycle. A trigger that arrives while busy is ignored.
- R10: Each pixel inside the buffer takes exactly three cycles:
  - a source read,
  - a destination read,
  - a write to the destination address.
  Read data is taken from mem_rdata_i in the cycle after the read request.
- R11: After reset, busy and done are low and the memory is neither read nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_xy_i | input | 32 | Source corner, x in bits 31:16 and y in bits 15:0 |
| dst_xy_i | input | 32 | Destination corner used by go_dst_i |
| start_xy_i | input | 32 | Start position, used as the destination by go_size_i |
| size_xy_i | input | 32 | Width in bits 31:16, height in bits 15:0 |
| go_dst_i | input | 1 | Trigger: copy to dst_xy_i |
| go_size_i | input | 1 | Trigger: copy to start_xy_i |
| rop_i | input | 4 | Raster-op code |
| plane_mask_i | input | 8 | Plane mask |
| ctrl_plane_i | input | 32 | Any non-zero value blocks triggers |
| mem_addr_o | output | AW | Pixel memory address |
| mem_re_o | output | 1 | Read request; data is returned one cycle later |
| mem_we_o | output | 1 | Write enable |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | A copy is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the environment:
- the memory returns read data exactly one cycle after mem_re_o;
- trigger pulses last one cycle;
- src_xy_i, dst_xy_i, start_xy_i and size_xy_i hold their values in the cycle a trigger is sampled.

The bench follows all three. Its memory model is a registered array. It drives every input at the falling edge and drops each trigger after one cycle. The only trigger it sends during a copy is the deliberate one that checks R9.

The bench runs on an 8 x 6 buffer. It sweeps a 3 x 3 block over every offset from -2 to +2 in each axis, which covers all four scan-direction cases and overlap on both sides. It also runs every one of the 16 raster-op codes, plus copies that fall off the end of the buffer.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
  } xy_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_SRC = 2'd1,
    ST_RD_DST = 2'd2,
    ST_WR     = 2'd3
  } st_t;

  localparam logic [3:0] ROP_CLR = 4'd0;
  localparam logic [3:0] ROP_CPY = 4'd3;
  localparam logic [3:0] ROP_XOR = 4'd6;
  localparam logic [3:0] ROP_INV = 4'd10;
  localparam logic [3:0] ROP_SET = 4'd15;
endpackage

// File: rtl/rcopy_rop.sv
module rcopy_rop #(
  parameter int PIX_W = 8
) (
  input  logic [3:0]       op_i,
  input  logic [PIX_W-1:0] mask_i,
  input  logic [PIX_W-1:0] src_i,
  input  logic [PIX_W-1:0] dst_i,
  output logic [PIX_W-1:0] res_o
);
  import rcopy_pkg::*;

  always_comb begin
    unique case (op_i)
      ROP_CLR: res_o = dst_i & ~mask_i;
      ROP_CPY: res_o = (dst_i & ~mask_i) | (src_i & mask_i);
      ROP_XOR: res_o = dst_i ^ (src_i & mask_i);
      ROP_INV: res_o = dst_i ^ mask_i;
      ROP_SET: res_o = dst_i | mask_i;
      default: res_o = dst_i;
    endcase
  end
endmodule

// File: rtl/rcopy_walk.sv
module rcopy_walk #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] w_i,
  input  logic [CW-1:0] h_i,
  input  logic          rev_x_i,
  input  logic          rev_y_i,
  input  logic          step_i,
  output logic [CW-1:0] col_o,
  output logic [CW-1:0] row_o,
  output logic          last_o
);
  logic [CW-1:0] w_q, h_q, cc_q, cr_q;
  logic          rx_q, ry_q;
  logic          row_end;

  assign row_end = (cc_q == w_q - 1'b1);
  assign last_o  = row_end && (cr_q == h_q - 1'b1);
  assign col_o   = rx_q ? (w_q - 1'b1 - cc_q) : cc_q;
  assign row_o   = ry_q ? (h_q - 1'b1 - cr_q) : cr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q  <= '0;
      h_q  <= '0;
      cc_q <= '0;
      cr_q <= '0;
      rx_q <= 1'b0;
      ry_q <= 1'b0;
    end else if (load_i) begin
      w_q  <= w_i;
      h_q  <= h_i;
      cc_q <= '0;
      cr_q <= '0;
      rx_q <= rev_x_i;
      ry_q <= rev_y_i;
    end else if (step_i) begin
      if (row_end) begin
        cc_q <= '0;
        cr_q <= last_o ? '0 : cr_q + 1'b1;
      end else begin
        cc_q <= cc_q + 1'b1;
      end
    end
  end

  // R2 R3: scan counters stay inside the loaded rectangle
  a_r3_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_q != '0) |-> (cc_q < w_q));
  a_r2_row_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q != '0) |-> (cr_q < h_q));
endmodule

// File: rtl/rcopy_addr.sv
module rcopy_addr #(
  parameter int PITCH    = 1280,
  parameter int BUF_SIZE = 1280 * 1024,
  parameter int AW       = 21
) (
  input  rcopy_pkg::xy_t base_i,
  input  logic [15:0]    col_i,
  input  logic [15:0]    row_i,
  output logic [AW-1:0]  addr_o,
  output logic           ok_o
);
  logic [31:0] lin;

  // R1: linear address = x + y * pitch
  assign lin    = (32'(base_i.x) + 32'(col_i)) + (32'(base_i.y) + 32'(row_i)) * 32'(PITCH);
  assign ok_o   = lin < 32'(BUF_SIZE);
  assign addr_o = lin[AW-1:0];
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine #(
  parameter int PITCH = 1280,
  parameter int ROWS  = 1024,
  parameter int PIX_W = 8,
  localparam int BUF_SIZE = PITCH * ROWS,
  localparam int AW       = $clog2(BUF_SIZE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      src_xy_i,
  input  logic [31:0]      dst_xy_i,
  input  logic [31:0]      start_xy_i,
  input  logic [31:0]      size_xy_i,
  input  logic             go_dst_i,
  input  logic             go_size_i,
  input  logic [3:0]       rop_i,
  input  logic [PIX_W-1:0] plane_mask_i,
  input  logic [31:0]      ctrl_plane_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [PIX_W-1:0] mem_wdata_o,
  input  logic [PIX_W-1:0] mem_rdata_i,
  output logic             busy_o,
  output logic             done_o
);
  import rcopy_pkg::*;

  st_t              st_q, st_d;
  xy_t              src_q, dst_q, src_in, dst_sel, size_in;
  logic [3:0]       rop_q;
  logic [PIX_W-1:0] pm_q, src_pix_q, rop_res;
  logic             done_q, done_d;
  logic             go, zero, step, last, fin;
  logic [15:0]      col, row;
  logic [AW-1:0]    s_addr, d_addr;
  logic             s_ok, d_ok;

  assign src_in  = xy_t'(src_xy_i);
  assign size_in = xy_t'(size_xy_i);
  // R6: go_dst has priority; size trigger targets the start position
  assign dst_sel = go_dst_i ? xy_t'(dst_xy_i) : xy_t'(start_xy_i);
  assign zero    = (size_in.x == '0) || (size_in.y == '0);
  // R7 R9: only accepted when idle and control plane is clear
  assign go      = (go_dst_i || go_size_i) && (st_q == ST_IDLE) && (ctrl_plane_i == '0);

  rcopy_walk #(.CW(16)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go && !zero),
    .w_i    (size_in.x),
    .h_i    (size_in.y),
    .rev_x_i(dst_sel.x > src_in.x),
    .rev_y_i(dst_sel.y > src_in.y),
    .step_i (step),
    .col_o  (col),
    .row_o  (row),
    .last_o (last)
  );

  rcopy_addr #(.PITCH(PITCH), .BUF_SIZE(BUF_SIZE), .AW(AW)) u_src_addr (
    .base_i(src_q), .col_i(col), .row_i(row), .addr_o(s_addr), .ok_o(s_ok)
  );

  rcopy_addr #(.PITCH(PITCH), .BUF_SIZE(BUF_SIZE), .AW(AW)) u_dst_addr (
    .base_i(dst_q), .col_i(col), .row_i(row), .addr_o(d_addr), .ok_o(d_ok)
  );

  rcopy_rop #(.PIX_W(PIX_W)) u_rop (
    .op_i  (rop_q),
    .mask_i(pm_q),
    .src_i (src_pix_q),
    .dst_i (mem_rdata_i),
    .res_o (rop_res)
  );

  always_comb begin
    st_d       = st_q;
    step       = 1'b0;
    fin        = 1'b0;
    mem_re_o   = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = d_addr;
    unique case (st_q)
      ST_IDLE: if (go && !zero) st_d = ST_RD_SRC;
      ST_RD_SRC: begin
        if (!(s_ok && d_ok)) begin
          // R5: out-of-range pixel costs one idle step
          step = 1'b1;
          if (last) begin
            fin  = 1'b1;
            st_d = ST_IDLE;
          end
        end else begin
          mem_re_o   = 1'b1;
          mem_addr_o = s_addr;
          st_d       = ST_RD_DST;
        end
      end
      ST_RD_DST: begin
        mem_re_o = 1'b1;
        st_d     = ST_WR;
      end
      ST_WR: begin
        mem_we_o = 1'b1;
        step     = 1'b1;
        if (last) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end else begin
          st_d = ST_RD_SRC;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign done_d      = fin || (go && zero);
  assign mem_wdata_o = rop_res;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      done_q    <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      rop_q     <= '0;
      pm_q      <= '0;
      src_pix_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (go) begin
        src_q <= src_in;
        dst_q <= dst_sel;
        rop_q <= rop_i;
        pm_q  <= plane_mask_i;
      end
      if (st_q == ST_RD_DST) src_pix_q <= mem_rdata_i;
    end
  end

  a_r10_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  a_r10_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));
  a_r5_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> (32'(mem_addr_o) < 32'(BUF_SIZE)));
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(src_q) && $stable(dst_q) && $stable(rop_q)));
  a_r7_ctrl_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((go_dst_i || go_size_i) && !busy_o && (ctrl_plane_i != '0)) |=> (!busy_o && !done_o));
  a_r8_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && zero) |=> (!busy_o && done_o));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_re_o || mem_we_o));
endmodule

// File: tb/tb_rect_copy_engine.sv
`timescale 1ns/1ps
module tb_rect_copy_engine;
  localparam int P   = 8;
  localparam int R   = 6;
  localparam int BUF = P * R;
  localparam int AW  = $clog2(BUF);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] src_xy, dst_xy, start_xy, size_xy, ctrl_plane;
  logic        go_dst, go_size;
  logic [3:0]  rop;
  logic [7:0]  pm;
  logic [AW-1:0] mem_addr;
  logic        mem_re, mem_we, busy, done;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] mem  [BUF];
  logic [7:0] gold [BUF];
  logic       ld;
  logic [7:0] seed;

  int total = 0, bad = 0;

  rect_copy_engine #(.PITCH(P), .ROWS(R), .PIX_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_xy_i(src_xy), .dst_xy_i(dst_xy), .start_xy_i(start_xy), .size_xy_i(size_xy),
    .go_dst_i(go_dst), .go_size_i(go_size), .rop_i(rop), .plane_mask_i(pm),
    .ctrl_plane_i(ctrl_plane),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    if (ld) begin
      for (int i = 0; i < BUF; i++) mem[i] <= 8'(i * 29 + int'(seed) * 7 + 3);
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [7:0] exp_rop(logic [3:0] op, logic [7:0] m, logic [7:0] s, logic [7:0] d);
    case (op)
      4'd0:  return d & ~m;
      4'd3:  return (d & ~m) | (s & m);
      4'd6:  return d ^ (s & m);
      4'd10: return d ^ m;
      4'd15: return d | m;
      default: return d;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mem(input logic [7:0] s);
    @(negedge clk); seed = s; ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    for (int i = 0; i < BUF; i++) gold[i] = 8'(i * 29 + int'(s) * 7 + 3);
  endtask

  task automatic cmp_mem(input string req);
    int nbad = 0, first = -1;
    for (int i = 0; i < BUF; i++)
      if (mem[i] !== gold[i]) begin
        nbad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(mem[first]), int'(gold[first]));
  endtask

  // expected result from R1..R5 ordering; returns expected busy cycles
  function automatic int model(int sx, int sy, int dx, int dy, int w, int h,
                               logic [3:0] op, logic [7:0] m);
    int cyc = 0;
    for (int r = 0; r < h; r++) begin
      int row = (dy > sy) ? h - 1 - r : r;
      for (int c = 0; c < w; c++) begin
        int col = (dx > sx) ? w - 1 - c : c;
        int sa = (sx + col) + (sy + row) * P;
        int da = (dx + col) + (dy + row) * P;
        if (sa >= BUF || da >= BUF) cyc += 1;
        else begin
          gold[da] = exp_rop(op, m, gold[sa], gold[da]);
          cyc += 3;
        end
      end
    end
    return cyc;
  endfunction

  task automatic run_op(input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input logic [3:0] op,
                        input logic [7:0] m, input bit via_size, input bit intrude,
                        input logic [7:0] s, input string req);
    int exp_cyc, cyc, guard;
    load_mem(s);
    exp_cyc = model(sx, sy, dx, dy, w, h, op, m);
    src_xy  = {16'(sx), 16'(sy)};
    size_xy = {16'(w), 16'(h)};
    rop = op; pm = m;
    if (via_size) begin
      start_xy = {16'(dx), 16'(dy)};
      dst_xy   = 32'h0000_0000;
      go_size  = 1'b1;
    end else begin
      start_xy = 32'h0001_0001;
      dst_xy   = {16'(dx), 16'(dy)};
      go_dst   = 1'b1;
    end
    @(negedge clk);
    go_dst = 1'b0; go_size = 1'b0;
    cyc = 0; guard = 0;
    while (!done && guard < 2000) begin
      if (busy) cyc++;
      if (intrude && cyc == 2) begin
        dst_xy = 32'h0; start_xy = 32'h0; rop = 4'd15; pm = 8'hff;
        go_dst = 1'b1; go_size = 1'b1;
      end else begin
        go_dst = 1'b0; go_size = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    go_dst = 1'b0; go_size = 1'b0;
    check(done && !busy, {req, " R9 done with busy low"}, int'(busy), 0);
    check(cyc == exp_cyc, {req, " R10 R5 busy cycles"}, cyc, exp_cyc);
    @(negedge clk);
    check(!done, {req, " R9 done one cycle"}, int'(done), 0);
    cmp_mem({req, " memory"});
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ld = 1'b0; seed = '0;
    src_xy = '0; dst_xy = '0; start_xy = '0; size_xy = '0; ctrl_plane = '0;
    go_dst = 1'b0; go_size = 1'b0; rop = 4'd3; pm = 8'hff;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R11 reset state", int'({busy, done, mem_re, mem_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R11 after reset", int'({busy, done, mem_re, mem_we}), 0);

    // R2 R3: 3x3 block against every offset in -2..2, overlapping both ways
    for (int oy = -2; oy <= 2; oy++)
      for (int ox = -2; ox <= 2; ox++)
        run_op(2, 2, 2 + ox, 2 + oy, 3, 3, 4'd3, 8'hff, 1'b0, 1'b0,
               8'((oy + 2) * 5 + ox + 2), "R2 R3 overlap sweep");

    // R4: every raster-op code with a partial plane mask
    for (int op = 0; op < 16; op++)
      run_op(0, 0, 4, 3, 3, 2, 4'(op), 8'h5a, 1'b0, 1'b0, 8'(op + 40), "R4 rop sweep");

    // R1: row wrap through the pitch, wide horizontal scrolls
    run_op(6, 0, 1, 3, 3, 2, 4'd3, 8'hff, 1'b0, 1'b0, 8'd70, "R1 pitch wrap");
    run_op(0, 1, 1, 1, 6, 2, 4'd6, 8'hf0, 1'b0, 1'b0, 8'd71, "R3 right scroll");
    run_op(2, 1, 0, 1, 6, 2, 4'd3, 8'h3c, 1'b0, 1'b0, 8'd72, "R3 left scroll");

    // R5: source rows and destination rows beyond the buffer
    run_op(1, 4, 4, 1, 3, 3, 4'd3, 8'hff, 1'b0, 1'b0, 8'd80, "R5 source off end");
    run_op(0, 1, 2, 5, 2, 2, 4'd3, 8'hff, 1'b0, 1'b0, 8'd81, "R5 dest off end");

    // R6: size trigger uses start position as destination
    run_op(0, 0, 3, 2, 4, 3, 4'd3, 8'hff, 1'b1, 1'b0, 8'd90, "R6 size trigger");
    run_op(3, 3, 2, 1, 3, 2, 4'd6, 8'h0f, 1'b1, 1'b0, 8'd91, "R6 size trigger up");

    // R8: zero width / zero height
    run_op(1, 1, 3, 3, 0, 2, 4'd15, 8'hff, 1'b0, 1'b0, 8'd95, "R8 zero width");
    run_op(1, 1, 3, 3, 2, 0, 4'd15, 8'hff, 1'b1, 1'b0, 8'd96, "R8 zero height");

    // R9: trigger while busy is ignored, rop and mask stay latched
    run_op(0, 0, 1, 1, 3, 3, 4'd3, 8'hff, 1'b0, 1'b1, 8'd97, "R9 busy trigger");

    // R7: control plane blocks the trigger
    load_mem(8'd99);
    ctrl_plane = 32'h0000_0100;
    src_xy = 32'h0; dst_xy = 32'h0002_0002; size_xy = 32'h0002_0002; rop = 4'd15; pm = 8'hff;
    go_dst = 1'b1;
    @(negedge clk);
    go_dst = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        if (busy || done || mem_we || mem_re) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R7 control plane ignored", seen, 0);
    end
    cmp_mem("R7 memory untouched");
    ctrl_plane = 32'h0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule